// File: doc/BRIEF.md
# Token-Aware L1 Access Checker

This block sits beside the L1 data cache and owns one metadata bit per token-sized slot of every line. A set bit means the slot holds the secret tripwire value. Each request arrives as an operation code, an address, a mode bit and the cache's hit indication. The block then decides whether the request completes, trips a token exception, or is rejected as an invalid instruction. The operations are load, store, arm and disarm. Arm is a wide write that only sets the slot's bit; the token value itself is written by the cache when the line is evicted. Disarm checks that bit, clears it and asks the data array to zero the slot.

On a miss the block asks for the line and waits for the fill. It then loads the slot bits from the fill detector's match flags and evaluates the request as if it had hit. Every accepted request ends in exactly one response on a valid/ready pair. An exception response carries the faulting address. There is no mask, so every token violation reaches the handler one privilege level up. The mode bit sets the store commit point. In debug mode a store commits only after its check passes, so exceptions are precise. In secure mode a store commits as soon as it is accepted, and its exception may arrive afterwards.

Top module: `l1_token_guard`

## Requirements
- R1: After reset the block is idle: req_ready is 1, rsp_valid and fetch_req are 0, and every token bit is clear, so a load to any line completes with code 0.
- R2: Each accepted request gives exactly one response. rsp_code 0 means done, 1 means token exception and 2 means invalid instruction. The response and its fields hold until rsp_ready, and req_ready stays 0 while a request is in flight.
- R3: An arm (req_op 2) or disarm (req_op 3) whose address has any of the low log2(TOKEN_BYTES) bits set responds with code 2 one cycle after acceptance. It fetches nothing and changes no token bit. This check takes priority over the token check.
- R4: A load (req_op 0) or store (req_op 1) to a slot whose token bit is set responds with code 1 and raises no data_en. To a clear slot it responds with code 0 and raises data_en for one cycle.
- R5: An arm to an aligned slot sets the bit without any data access and responds with code 0. On a hit it responds one cycle after acceptance.
- R6: A disarm whose slot bit is clear responds with code 1 and raises no zero_en.
- R7: A disarm whose slot bit is set clears it and raises zero_en for one cycle with the token-aligned address on zero_addr. It responds with code 0 two cycles after acceptance.
- R8: On a miss, fetch_req stays high until fill_valid. The line's bits then take fill_tokens, and the request is evaluated as a hit. An arm that misses sets its bit after the fill.
- R9: A store in secure mode (req_debug 0) raises commit in its acceptance cycle, whatever the outcome. A store in debug mode (req_debug 1) raises commit only when its check succeeds, and never when it raises an exception.
- R10: rsp_fault_addr equals the request address when the code is nonzero and 0 when the code is 0. No input can suppress a token exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 load, 1 store, 2 arm, 3 disarm |
| req_addr | input | ADDR_W | Byte address of the access |
| req_debug | input | 1 | 1 debug (precise) mode, 0 secure mode |
| req_hit | input | 1 | The line is present in the cache |
| fill_valid | input | 1 | Line fill for the pending miss has arrived |
| fill_tokens | input | LINE_BYTES/TOKEN_BYTES | Per-slot token match flags of the fill |
| fetch_req | output | 1 | Line fetch requested for the pending miss |
| data_en | output | 1 | Load/store may use the data array |
| zero_en | output | 1 | Zero the token slot at zero_addr |
| zero_addr | output | ADDR_W | Token-aligned address to zero |
| commit | output | 1 | Store commit strobe |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_code | output | 2 | 0 done, 1 token exception, 2 invalid instruction |
| rsp_fault_addr | output | ADDR_W | Faulting address, 0 on success |

## Verification
A behavioural token map in the bench predicts each response. It is driven with loads and stores to armed and clear slots, which separates a missing bit test from a wrong line index. Misaligned arm and disarm, aimed at both armed and clear lines, separate the priority order from the bit test. Misses with a set and a clear fill flag show that the fill updates the bits before evaluation. Stores are run in both modes against armed and clear slots, which separates early from checked commit. A backpressured response and an arm pass over even lines followed by a load pass over all lines round out the patterns.

// File: rtl/tokguard_pkg.sv
package tokguard_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ARM    = 2'd2,
    OP_DISARM = 2'd3
  } tok_op_e;

  typedef enum logic [1:0] {
    RC_DONE    = 2'd0,
    RC_TOKEN   = 2'd1,
    RC_INVALID = 2'd2
  } tok_rc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MISS,
    ST_RETRY,
    ST_ZERO,
    ST_RESP
  } tok_st_e;
endpackage

// File: rtl/tokguard_decode.sv
module tokguard_decode
  import tokguard_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_LINES   = 16,
  parameter int LINE_BYTES  = 64,
  parameter int TOKEN_BYTES = 64
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [1:0]                        op,
  output logic [$clog2(NUM_LINES)-1:0]      line_idx,
  output logic [((LINE_BYTES/TOKEN_BYTES) > 1 ? $clog2(LINE_BYTES/TOKEN_BYTES) : 1)-1:0] slot_idx,
  output logic                              misaligned,
  output logic [ADDR_W-1:0]                 aligned_addr
);
  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int TOK_OFF  = $clog2(TOKEN_BYTES);
  localparam int IDX_W    = $clog2(NUM_LINES);
  localparam int TPL      = LINE_BYTES / TOKEN_BYTES;
  localparam int SLOT_W   = (TPL > 1) ? $clog2(TPL) : 1;

  logic wide_op;

  assign line_idx = addr[LINE_OFF +: IDX_W];

  generate
    if (TPL > 1) begin : g_multi_slot
      assign slot_idx = addr[TOK_OFF +: SLOT_W];
    end else begin : g_single_slot
      assign slot_idx = '0;
    end
  endgenerate

  assign wide_op      = (op == OP_ARM) || (op == OP_DISARM);
  assign misaligned   = wide_op && (addr[TOK_OFF-1:0] != '0);
  assign aligned_addr = {addr[ADDR_W-1:TOK_OFF], {TOK_OFF{1'b0}}};
endmodule

// File: rtl/tokguard_bits.sv
module tokguard_bits #(
  parameter int NUM_LINES = 16,
  parameter int TPL       = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_LINES)-1:0] line_idx,
  input  logic [((TPL > 1) ? $clog2(TPL) : 1)-1:0] slot_idx,
  output logic                         rd_bit,
  input  logic                         set_en,
  input  logic                         clr_en,
  input  logic                         fill_en,
  input  logic [TPL-1:0]               fill_vec
);
  logic [NUM_LINES-1:0][TPL-1:0] bits_q;
  logic [NUM_LINES-1:0][TPL-1:0] bits_d;
  logic                          bits_we;

  assign rd_bit  = bits_q[line_idx][slot_idx];
  assign bits_we = set_en | clr_en | fill_en;

  always_comb begin
    bits_d = bits_q;
    if (fill_en) bits_d[line_idx] = fill_vec;
    if (set_en)  bits_d[line_idx][slot_idx] = 1'b1;
    if (clr_en)  bits_d[line_idx][slot_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (bits_we) bits_q <= bits_d;
  end
endmodule

// File: rtl/tokguard_ctrl.sv
module tokguard_ctrl
  import tokguard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_debug,
  input  logic              req_hit,
  input  logic              fill_valid,
  input  logic              rsp_ready,
  input  logic              tok_bit,
  input  logic              misaligned,
  output logic [1:0]        cur_op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              req_ready,
  output logic              fetch_req,
  output logic              set_en,
  output logic              clr_en,
  output logic              fill_en,
  output logic              data_en,
  output logic              zero_en,
  output logic              commit,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_fault_addr
);
  tok_st_e           state_q, state_d;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dbg_q;
  logic [1:0]        code_q, code_d;
  logic              in_idle, accept, eval_go, cur_dbg;

  assign in_idle  = (state_q == ST_IDLE);
  assign accept   = in_idle && req_valid;
  assign cur_op   = in_idle ? req_op    : op_q;
  assign cur_addr = in_idle ? req_addr  : addr_q;
  assign cur_dbg  = in_idle ? req_debug : dbg_q;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    eval_go = 1'b0;
    set_en  = 1'b0;
    clr_en  = 1'b0;
    fill_en = 1'b0;
    data_en = 1'b0;
    zero_en = 1'b0;
    commit  = accept && (req_op == OP_STORE) && !req_debug;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (misaligned) begin
            code_d  = RC_INVALID;
            state_d = ST_RESP;
          end else if (!req_hit) begin
            state_d = ST_MISS;
          end else begin
            eval_go = 1'b1;
          end
        end
      end
      ST_MISS: begin
        if (fill_valid) begin
          fill_en = 1'b1;
          state_d = ST_RETRY;
        end
      end
      ST_RETRY: eval_go = 1'b1;
      ST_ZERO: begin
        zero_en = 1'b1;
        state_d = ST_RESP;
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (eval_go) begin
      state_d = ST_RESP;
      unique case (cur_op)
        OP_LOAD, OP_STORE: begin
          if (tok_bit) begin
            code_d = RC_TOKEN;
          end else begin
            code_d  = RC_DONE;
            data_en = 1'b1;
            if ((cur_op == OP_STORE) && cur_dbg) commit = 1'b1;
          end
        end
        OP_ARM: begin
          set_en = 1'b1;
          code_d = RC_DONE;
        end
        OP_DISARM: begin
          if (tok_bit) begin
            clr_en  = 1'b1;
            code_d  = RC_DONE;
            state_d = ST_ZERO;
          end else begin
            code_d = RC_TOKEN;
          end
        end
        default: code_d = RC_INVALID;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= RC_DONE;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      dbg_q  <= 1'b0;
    end else if (accept) begin
      op_q   <= req_op;
      addr_q <= req_addr;
      dbg_q  <= req_debug;
    end
  end

  assign req_ready      = in_idle;
  assign fetch_req      = (state_q == ST_MISS);
  assign rsp_valid      = (state_q == ST_RESP);
  assign rsp_code       = code_q;
  assign rsp_fault_addr = (code_q != RC_DONE) ? addr_q : '0;
endmodule

// File: rtl/l1_token_guard.sv
module l1_token_guard #(
  parameter int ADDR_W      = 32,
  parameter int NUM_LINES   = 16,
  parameter int LINE_BYTES  = 64,
  parameter int TOKEN_BYTES = 64
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [1:0]                          req_op,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic                                req_debug,
  input  logic                                req_hit,
  input  logic                                fill_valid,
  input  logic [LINE_BYTES/TOKEN_BYTES-1:0]   fill_tokens,
  output logic                                fetch_req,
  output logic                                data_en,
  output logic                                zero_en,
  output logic [ADDR_W-1:0]                   zero_addr,
  output logic                                commit,
  output logic                                rsp_valid,
  input  logic                                rsp_ready,
  output logic [1:0]                          rsp_code,
  output logic [ADDR_W-1:0]                   rsp_fault_addr
);
  localparam int TPL    = LINE_BYTES / TOKEN_BYTES;
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int SLOT_W = (TPL > 1) ? $clog2(TPL) : 1;

  logic [1:0]        cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  line_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic              misaligned, tok_bit;
  logic              set_en, clr_en, fill_en;

  tokguard_decode #(
    .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES),
    .LINE_BYTES(LINE_BYTES), .TOKEN_BYTES(TOKEN_BYTES)
  ) u_decode (
    .addr(cur_addr), .op(cur_op), .line_idx(line_idx), .slot_idx(slot_idx),
    .misaligned(misaligned), .aligned_addr(zero_addr)
  );

  tokguard_bits #(.NUM_LINES(NUM_LINES), .TPL(TPL)) u_bits (
    .clk(clk), .rst_n(rst_n), .line_idx(line_idx), .slot_idx(slot_idx),
    .rd_bit(tok_bit), .set_en(set_en), .clr_en(clr_en),
    .fill_en(fill_en), .fill_vec(fill_tokens)
  );

  tokguard_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_debug(req_debug), .req_hit(req_hit),
    .fill_valid(fill_valid), .rsp_ready(rsp_ready), .tok_bit(tok_bit),
    .misaligned(misaligned), .cur_op(cur_op), .cur_addr(cur_addr),
    .req_ready(req_ready), .fetch_req(fetch_req), .set_en(set_en),
    .clr_en(clr_en), .fill_en(fill_en), .data_en(data_en),
    .zero_en(zero_en), .commit(commit), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_fault_addr(rsp_fault_addr)
  );
endmodule

// File: rtl/l1_token_guard_chk.sv
module l1_token_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              fetch_req,
  input logic              fill_valid,
  input logic              data_en,
  input logic              zero_en,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_fault_addr
);
  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R2
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_fault_addr));

  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code != 2'd3);

  // R7
  zero_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_en |=> rsp_valid && rsp_code == 2'd0);

  // R8
  fill_ends_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fill_valid |=> !fetch_req);

  // R10
  ok_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == 2'd0 |-> rsp_fault_addr == '0);

  // R4
  data_zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_en && zero_en));
endmodule

bind l1_token_guard l1_token_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .fetch_req(fetch_req),
  .fill_valid(fill_valid), .data_en(data_en), .zero_en(zero_en),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
  .rsp_fault_addr(rsp_fault_addr)
);

// File: tb/l1_token_guard_bench.sv
`timescale 1ns/1ps
module l1_token_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_debug = 1'b0, req_hit = 1'b1;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic        fill_valid = 1'b0;
  logic [0:0]  fill_tokens = '0;
  logic        fetch_req, data_en, zero_en, commit, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] zero_addr, rsp_fault_addr;
  logic [1:0]  rsp_code;

  int total = 0;
  int bad = 0;
  bit ref_bits [16];
  bit done = 0;

  always #5 clk = ~clk;

  l1_token_guard u_l1_token_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_debug(req_debug), .req_hit(req_hit),
    .fill_valid(fill_valid), .fill_tokens(fill_tokens), .fetch_req(fetch_req),
    .data_en(data_en), .zero_en(zero_en), .zero_addr(zero_addr), .commit(commit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_fault_addr(rsp_fault_addr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [31:0] addr, input logic dbg,
                         input logic hit, input logic fillv, input int bp, input string rq);
    int  line, lat, n_data, n_zero, n_commit, n_fetch, exp_lat;
    bit  mis, filled, seen, okv;
    logic [1:0]  ecode;
    logic [31:0] zaddr;
    int  e_data, e_zero, e_commit;
    line = int'((addr >> 6) & 32'hF);
    mis  = (op >= 2'd2) && (addr[5:0] != 6'd0);
    e_data = 0; e_zero = 0; e_commit = 0; exp_lat = 1;
    if (!mis && !hit) ref_bits[line] = fillv;
    if (mis) ecode = 2'd2;
    else begin
      case (op)
        2'd0, 2'd1: begin
          ecode = ref_bits[line] ? 2'd1 : 2'd0;
          if (ecode == 2'd0) e_data = 1;
        end
        2'd2: begin ecode = 2'd0; ref_bits[line] = 1'b1; end
        default: begin
          if (ref_bits[line]) begin
            ecode = 2'd0; ref_bits[line] = 1'b0; e_zero = 1; exp_lat = 2;
          end else ecode = 2'd1;
        end
      endcase
    end
    if (op == 2'd1 && (!dbg || ecode == 2'd0)) e_commit = 1;

    n_data = 0; n_zero = 0; n_commit = 0; n_fetch = 0; zaddr = '0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_debug = dbg; req_hit = hit;
    rsp_ready = (bp == 0);
    #1;
    n_data += int'(data_en); n_commit += int'(commit);
    if (zero_en) begin n_zero++; zaddr = zero_addr; end
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; filled = 0; seen = 0;
    while (lat < 200) begin
      n_data += int'(data_en); n_commit += int'(commit);
      if (zero_en) begin n_zero++; zaddr = zero_addr; end
      fill_valid = 1'b0;
      if (fetch_req && !filled) begin
        fill_valid = 1'b1; fill_tokens = fillv; filled = 1; n_fetch++;
      end
      if (rsp_valid) begin seen = 1; break; end
      @(negedge clk);
      lat++;
    end
    fill_valid = 1'b0;
    chk(seen, rq, "response seen", seen, 1);
    chk(rsp_code == ecode, rq, "rsp_code", rsp_code, ecode);
    chk(rsp_fault_addr == ((ecode != 2'd0) ? addr : 32'd0), rq, "fault addr",
        rsp_fault_addr, (ecode != 2'd0) ? addr : 32'd0);
    chk(n_data == e_data, rq, "data_en count", n_data, e_data);
    chk(n_zero == e_zero, rq, "zero_en count", n_zero, e_zero);
    if (e_zero != 0) chk(zaddr == {addr[31:6], 6'd0}, rq, "zero_addr", zaddr, {addr[31:6], 6'd0});
    chk(n_commit == e_commit, rq, "commit count", n_commit, e_commit);
    chk(n_fetch == ((!mis && !hit) ? 1 : 0), rq, "fetch count", n_fetch, (!mis && !hit) ? 1 : 0);
    if (hit || mis) chk(lat == exp_lat, rq, "latency", lat, exp_lat);
    if (bp > 0) begin
      for (int i = 0; i < bp; i++) begin
        @(negedge clk);
        okv = rsp_valid && !req_ready && (rsp_code == ecode);
        chk(okv, "R2", "held under backpressure", {rsp_valid, req_ready}, 2'b10);
      end
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R2", "single response then idle", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_bits[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fetch_req, "R1", "reset state",
        {req_ready, rsp_valid, fetch_req}, 3'b100);
    run_req(2'd0, 32'h1000, 0, 1, 0, 0, "R1");
    run_req(2'd2, 32'h1040, 0, 1, 0, 0, "R5");
    run_req(2'd0, 32'h1048, 0, 1, 0, 0, "R4");
    run_req(2'd1, 32'h1050, 0, 1, 0, 0, "R9");
    run_req(2'd1, 32'h1050, 1, 1, 0, 0, "R9");
    run_req(2'd2, 32'h1084, 0, 1, 0, 0, "R3");
    run_req(2'd0, 32'h1080, 0, 1, 0, 0, "R3");
    run_req(2'd3, 32'h1044, 0, 1, 0, 0, "R3");
    run_req(2'd0, 32'h1040, 0, 1, 0, 0, "R3");
    run_req(2'd2, 32'h10C8, 0, 0, 1, 0, "R3");
    run_req(2'd3, 32'h10C0, 0, 1, 0, 0, "R6");
    run_req(2'd3, 32'h1040, 0, 1, 0, 0, "R7");
    run_req(2'd0, 32'h1040, 0, 1, 0, 0, "R7");
    run_req(2'd0, 32'h1100, 0, 0, 1, 0, "R8");
    run_req(2'd0, 32'h1100, 0, 1, 0, 0, "R8");
    run_req(2'd2, 32'h1140, 0, 0, 0, 0, "R8");
    run_req(2'd1, 32'h1140, 1, 1, 0, 0, "R8");
    run_req(2'd3, 32'h1100, 0, 0, 1, 0, "R8");
    run_req(2'd1, 32'h1180, 1, 1, 0, 0, "R9");
    run_req(2'd1, 32'h1180, 0, 1, 0, 0, "R9");
    run_req(2'd0, 32'h1140, 0, 1, 0, 3, "R2");
    run_req(2'd0, 32'h1000, 0, 1, 0, 2, "R2");
    for (int l = 0; l < 16; l += 2) run_req(2'd2, 32'h2000 + l * 64, 0, 1, 0, 0, "R5");
    for (int l = 0; l < 16; l++)    run_req(2'd0, 32'h2000 + l * 64 + 8, 0, 1, 0, 0, "R10");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule